// File: doc/BRIEF.md
# Cascaded Two-Stage Channel Clock Divider

This block divides an input clock by a programmable ratio built from two stages in series. Each stage has a 4-bit high-count field and a 4-bit low-count field. An active stage divides by high + low + 2, and a bypassed stage divides by one. The first stage counts every input cycle. The second stage advances once per wrap of the first, so the whole chain divides by the product of the two ratios. That product runs from 1 to 1024.

The final output has two modes. With duty-cycle correction on (the default, `dcc_off` low), it is high for the lower half of the total ratio and low for the rest, whatever the split between the high and low fields. With correction off, it follows the high/low waveform of the last active stage.

The configuration inputs are captured only on a restart: reset or a one-cycle synchronous `sync_req`. A restart clears both stages together, so every output of a group of these dividers starts from the same phase. A total ratio of one sends the input clock straight through a multiplexer whose select comes from a register.

Top module: `cascade_div`

## Requirements
- R1: With both bypass bits set, `clk_out` equals `clk_in`: high while `clk_in` is high and low while it is low.
- R2: With only the second stage bypassed, the period of `clk_out` is s1_high + s1_low + 2 input cycles.
- R3: With only the first stage bypassed, the period is s2_high + s2_low + 2 input cycles.
- R4: With neither stage bypassed, the period is (s1_high + s1_low + 2) × (s2_high + s2_low + 2) input cycles, reaching 1024 when all four fields are 15.
- R5: With `dcc_off` = 0 and a total ratio D ≥ 2, `clk_out` is high for floor(D/2) input cycles and low for the remaining cycles of each period.
- R6: With `dcc_off` = 1 and the second stage active, `clk_out` is high for (s2_high + 1) × d1 input cycles, where d1 is the first stage's ratio (1 if bypassed). With `dcc_off` = 1 and only the second stage bypassed, it is high for s1_high + 1 cycles.
- R7: The clock edge that samples `rst` or `sync_req` high drives `clk_out` low for the next cycle (ratio ≥ 2). The following edge, with the restart gone, drives it high at the start of a new period.
- R8: The field, bypass and `dcc_off` inputs are captured only at a restart. Changing them without a restart leaves the period and the high time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset; also captures the configuration |
| sync_req | input | 1 | Synchronous restart of both stages; captures the configuration |
| s1_high | input | 4 | First stage high-count field |
| s1_low | input | 4 | First stage low-count field |
| s2_high | input | 4 | Second stage high-count field |
| s2_low | input | 4 | Second stage low-count field |
| s1_bypass | input | 1 | First stage divides by one when set |
| s2_bypass | input | 1 | Second stage divides by one when set |
| dcc_off | input | 1 | Set to disable duty-cycle correction |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions assume that `clk_in` is the only clock and that `sync_req` and the configuration inputs are synchronous to it. They also assume the configuration matters only at the edge where a restart is sampled. Because of that, the checks on captured configuration and restart phase are stated against the restart edge and not against input changes. The bench changes inputs only on falling edges. It follows every configuration change with a one-cycle sync pulse, except in the one test that deliberately changes fields without a sync to show they are ignored.

// File: rtl/div_pkg.sv
package div_pkg;

    localparam int FLD_W = 4;
    localparam int STG_W = FLD_W + 2;
    localparam int TOT_W = 2 * STG_W;

    typedef struct packed {
        logic [FLD_W-1:0] hi;
        logic [FLD_W-1:0] lo;
        logic             bypass;
    } stage_cfg_t;

    typedef struct packed {
        stage_cfg_t st1;
        stage_cfg_t st2;
        logic       dcc_off;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        MODE_PASS,
        MODE_EVEN,
        MODE_STG1,
        MODE_STG2
    } out_mode_e;

    function automatic logic [STG_W-1:0] stage_ratio(stage_cfg_t c);
        if (c.bypass) begin
            return STG_W'(1);
        end
        return STG_W'(c.hi) + STG_W'(c.lo) + STG_W'(2);
    endfunction

    function automatic logic [TOT_W-1:0] chain_ratio(chan_cfg_t c);
        return TOT_W'(stage_ratio(c.st1)) * TOT_W'(stage_ratio(c.st2));
    endfunction

    function automatic out_mode_e pick_mode(chan_cfg_t c);
        if (c.st1.bypass && c.st2.bypass) begin
            return MODE_PASS;
        end
        if (!c.dcc_off) begin
            return MODE_EVEN;
        end
        if (!c.st2.bypass) begin
            return MODE_STG2;
        end
        return MODE_STG1;
    endfunction

endpackage

// File: rtl/div_stage.sv
module div_stage
    import div_pkg::*;
(
    input  logic       clk,
    input  logic       restart,
    input  logic       step,
    input  stage_cfg_t cfg,
    output logic       wrap,
    output logic       level
);

    logic [STG_W-1:0] cnt_q;
    logic [STG_W-1:0] last_cnt;
    logic             at_end;

    assign last_cnt = stage_ratio(cfg) - STG_W'(1);
    assign at_end   = (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (restart) begin
            cnt_q <= '0;
        end else if (step && !cfg.bypass) begin
            cnt_q <= at_end ? '0 : cnt_q + STG_W'(1);
        end
    end

    // a stage wraps on the last step of its period; a bypassed stage on every step
    assign wrap  = step && (cfg.bypass || at_end);
    assign level = cfg.bypass || (cnt_q <= STG_W'(cfg.hi));

endmodule

// File: rtl/div_even.sv
module div_even
    import div_pkg::*;
(
    input  logic             clk,
    input  logic             restart,
    input  logic             frame_end,
    input  logic [TOT_W-1:0] total,
    output logic [TOT_W-1:0] pos,
    output logic             level
);

    logic [TOT_W-1:0] pos_q;
    logic [TOT_W-1:0] half;

    assign half = total >> 1;

    always_ff @(posedge clk) begin
        if (restart || frame_end) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + TOT_W'(1);
        end
    end

    assign pos   = pos_q;
    assign level = (pos_q < half);

endmodule

// File: rtl/div_outsel.sv
module div_outsel
    import div_pkg::*;
(
    input  logic      clk,
    input  logic      restart,
    input  out_mode_e mode,
    input  logic      lvl_even,
    input  logic      lvl_st1,
    input  logic      lvl_st2,
    output logic      out_q
);

    logic sel;

    always_comb begin
        unique case (mode)
            MODE_EVEN: sel = lvl_even;
            MODE_STG1: sel = lvl_st1;
            MODE_STG2: sel = lvl_st2;
            default:   sel = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            out_q <= 1'b0;
        end else begin
            out_q <= sel;
        end
    end

endmodule

// File: rtl/cascade_div.sv
module cascade_div
    import div_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst,
    input  logic             sync_req,
    input  logic [FLD_W-1:0] s1_high,
    input  logic [FLD_W-1:0] s1_low,
    input  logic [FLD_W-1:0] s2_high,
    input  logic [FLD_W-1:0] s2_low,
    input  logic             s1_bypass,
    input  logic             s2_bypass,
    input  logic             dcc_off,
    output logic             clk_out
);

    chan_cfg_t        cfg_in;
    chan_cfg_t        cfg_q;
    out_mode_e        mode_q;
    logic             pass_q;
    logic             restart;
    logic             tick1;
    logic             tick2;
    logic             lvl1;
    logic             lvl2;
    logic             lvl_even;
    logic             out_q;
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] even_pos;

    assign restart = rst || sync_req;

    always_comb begin
        cfg_in.st1.hi     = s1_high;
        cfg_in.st1.lo     = s1_low;
        cfg_in.st1.bypass = s1_bypass;
        cfg_in.st2.hi     = s2_high;
        cfg_in.st2.lo     = s2_low;
        cfg_in.st2.bypass = s2_bypass;
        cfg_in.dcc_off    = dcc_off;
    end

    // configuration and output mode are taken only at a restart
    always_ff @(posedge clk_in) begin
        if (restart) begin
            cfg_q  <= cfg_in;
            mode_q <= pick_mode(cfg_in);
            pass_q <= s1_bypass && s2_bypass;
        end
    end

    assign total = chain_ratio(cfg_q);

    div_stage u_stage1 (
        .clk     (clk_in),
        .restart (restart),
        .step    (1'b1),
        .cfg     (cfg_q.st1),
        .wrap    (tick1),
        .level   (lvl1)
    );

    div_stage u_stage2 (
        .clk     (clk_in),
        .restart (restart),
        .step    (tick1),
        .cfg     (cfg_q.st2),
        .wrap    (tick2),
        .level   (lvl2)
    );

    div_even u_even (
        .clk       (clk_in),
        .restart   (restart),
        .frame_end (tick2),
        .total     (total),
        .pos       (even_pos),
        .level     (lvl_even)
    );

    div_outsel u_outsel (
        .clk      (clk_in),
        .restart  (restart),
        .mode     (mode_q),
        .lvl_even (lvl_even),
        .lvl_st1  (lvl1),
        .lvl_st2  (lvl2),
        .out_q    (out_q)
    );

    // the select is a register, so the multiplexer changes only after a restart edge
    assign clk_out = pass_q ? clk_in : out_q;

endmodule

// File: rtl/cascade_div_chk.sv
module cascade_div_chk
    import div_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             restart,
    input logic             out_q,
    input logic             tick1,
    input logic             tick2,
    input logic             pass_q,
    input logic [TOT_W-1:0] pos,
    input logic [TOT_W-1:0] total,
    input chan_cfg_t        cfg_q,
    input chan_cfg_t        cfg_in
);

    assert_pass_every_R1: assert property (@(posedge clk) disable iff (rst)
        pass_q |-> tick2);

    assert_frame_nested_R4: assert property (@(posedge clk) disable iff (rst)
        tick2 |-> tick1);

    assert_pos_bound_R5: assert property (@(posedge clk) disable iff (rst)
        pos < total);

    assert_restart_low_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !out_q);

    assert_first_high_R7: assert property (@(posedge clk) disable iff (rst)
        restart ##1 !restart |=> out_q);

    assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(cfg_q));

    assert_capture_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cfg_q == $past(cfg_in)));

endmodule

bind cascade_div cascade_div_chk u_chk (
    .clk     (clk_in),
    .rst     (rst),
    .restart (restart),
    .out_q   (out_q),
    .tick1   (tick1),
    .tick2   (tick2),
    .pass_q  (pass_q),
    .pos     (even_pos),
    .total   (total),
    .cfg_q   (cfg_q),
    .cfg_in  (cfg_in)
);

// File: tb/cascade_div_test.sv
module cascade_div_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_req = 1'b0;
    logic [3:0] s1_high = 4'd1;
    logic [3:0] s1_low = 4'd4;
    logic [3:0] s2_high = 4'd0;
    logic [3:0] s2_low = 4'd0;
    logic       s1_bypass = 1'b0;
    logic       s2_bypass = 1'b1;
    logic       dcc_off = 1'b0;
    logic       clk_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cascade_div uut (
        .clk_in    (clk),
        .rst       (rst),
        .sync_req  (sync_req),
        .s1_high   (s1_high),
        .s1_low    (s1_low),
        .s2_high   (s2_high),
        .s2_low    (s2_low),
        .s1_bypass (s1_bypass),
        .s2_bypass (s2_bypass),
        .dcc_off   (dcc_off),
        .clk_out   (clk_out)
    );

    // n1, m1, n2, m2, bypass1, bypass2, dcc_off, period, high, requirement pair
    localparam int NV = 12;
    localparam int VEC [NV][9] = '{
        '{ 1,  4,  0,  0, 0, 1, 0,    7,   3},
        '{ 1,  4,  0,  0, 0, 1, 1,    7,   2},
        '{ 0,  0,  5,  2, 1, 0, 0,    9,   4},
        '{ 0,  0,  5,  2, 1, 0, 1,    9,   6},
        '{ 2,  1,  0,  1, 0, 0, 0,   15,   7},
        '{ 2,  1,  0,  1, 0, 0, 1,   15,   5},
        '{15, 15, 15, 15, 0, 0, 0, 1024, 512},
        '{15, 15, 15, 15, 0, 0, 1, 1024, 512},
        '{ 0,  0,  0,  0, 0, 1, 0,    2,   1},
        '{ 0,  0,  2,  0, 0, 0, 1,    8,   6},
        '{ 0, 15,  0,  0, 0, 1, 0,   17,   8},
        '{ 0, 15,  0,  0, 0, 1, 1,   17,   1}
    };
    localparam string RPER [NV] = '{"R2", "R2", "R3", "R3", "R4", "R4",
                                    "R4", "R4", "R2", "R4", "R2", "R2"};
    localparam string RHI  [NV] = '{"R5", "R6", "R5", "R6", "R5", "R6",
                                    "R5", "R6", "R5", "R6", "R5", "R6"};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic set_cfg(input int i);
        s1_high   = 4'(VEC[i][0]);
        s1_low    = 4'(VEC[i][1]);
        s2_high   = 4'(VEC[i][2]);
        s2_low    = 4'(VEC[i][3]);
        s1_bypass = VEC[i][4][0];
        s2_bypass = VEC[i][5][0];
        dcc_off   = VEC[i][6][0];
    endtask

    // called at a falling edge where clk_out has just become high
    task automatic measure(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (clk_out === 1'b1 && hi < 2000) begin
            hi++;
            @(negedge clk);
        end
        while (clk_out === 1'b0 && lo < 2000) begin
            lo++;
            @(negedge clk);
        end
    endtask

    task automatic sync_and_check_phase(input string req);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        check({req, " low after restart"}, int'(clk_out), 0);
        @(negedge clk);
        check({req, " high one edge later"}, int'(clk_out), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1..R8 watchdog actual=timeout expected=finished");
        summary_and_end();
    end

    initial begin
        int hi;
        int lo;

        // reset state, R7
        repeat (3) @(negedge clk);
        check("R7 output low in reset", int'(clk_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 output high after reset release", int'(clk_out), 1);

        // table of bypass / correction combinations
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_cfg(i);
            sync_and_check_phase("R7");
            measure(hi, lo);
            check({RHI[i], " high time"}, hi, VEC[i][8]);
            check({RPER[i], " period"}, hi + lo, VEC[i][7]);
        end

        // R8: fields change without a restart, old ratio persists
        set_cfg(4);
        sync_and_check_phase("R7");
        set_cfg(0);
        repeat (3) @(negedge clk);
        while (clk_out === 1'b1) @(negedge clk);
        while (clk_out === 1'b0) @(negedge clk);
        measure(hi, lo);
        check("R8 high unchanged without sync", hi, 7);
        check("R8 period unchanged without sync", hi + lo, 15);
        sync_and_check_phase("R8");
        measure(hi, lo);
        check("R8 period after sync", hi + lo, 7);

        // R1: total ratio one passes the input clock
        s1_bypass = 1'b1;
        s2_bypass = 1'b1;
        sync_req  = 1'b1;
        @(negedge clk);
        sync_req  = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            #2;
            check("R1 follows clock high", int'(clk_out), 1);
            @(negedge clk);
            #2;
            check("R1 follows clock low", int'(clk_out), 0);
        end

        // back to a divided ratio, then a reset in the middle of a period
        @(negedge clk);
        set_cfg(4);
        sync_and_check_phase("R7");
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 low after mid-period reset", int'(clk_out), 0);
        @(negedge clk);
        check("R7 high after mid-period reset", int'(clk_out), 1);
        measure(hi, lo);
        check("R4 period after reset", hi + lo, 15);

        summary_and_end();
    end

endmodule